// File: doc/BRIEF.md
# Local Scan Port Park Controller

This block sits behind a backplane scan bridge and governs three local scan ports. Each port drives its own local test-mode-select line (`tms_l`). A port is either parked or live. A parked port holds its local TAP in Test-Logic-Reset (line held high) or in Run-Test/Idle (line held low). A live port passes the backplane TMS straight through. When a port is live its scan data is spliced into the serial path between `scan_in` and `scan_out`.

The bridge instruction decoder pulses one-cycle command strobes: unpark, park-to-reset, park-to-idle, soft reset and return-to-wait. The 8-bit mode register chooses which ports those commands act on. An unpark request does not take effect at once. The port stays parked until the bridge TAP leaves the same state that the local TAP is parked in. At that point the two controllers step out together and stay aligned. Because a port can be parked in Run-Test/Idle, a local instruction such as an external test stays in force while the bridge is deselected, and the port can later rejoin in step.

The scan path is serial, bit-level and timed by TCK, so it has no valid/ready handshake. Every TCK edge moves one bit, and back-pressure does not apply. All pins are plain levels sampled on the rising edge of `tck`. `trst_n` is an asynchronous active-low reset.

Top module: `lsp_park_ctrl`

## Requirements
- R1: While `trst_n` is low and after it is released, before any command, every port is parked in Test-Logic-Reset: `tms_l` = 3'b111 and `scan_out` equals `scan_in`.
- R2: Mode bit k (k = 0..2) enables the port at `tms_l[k]`. Bits 7..3 are ignored. Unpark, park-to-reset and park-to-idle leave disabled ports unchanged.
- R3: After unpark, a port parked in Test-Logic-Reset keeps `tms_l` high while `brg_state` is not 4'hF. While `brg_state` is 4'hF, its `tms_l` equals `tms`. If `tms` is 0 at that rising edge, the port goes live, and from then on `tms_l` equals `tms`.
- R4: After unpark, a port parked in Run-Test/Idle keeps `tms_l` low while `brg_state` is not 4'hC. While `brg_state` is 4'hC, its `tms_l` equals `tms`. If `tms` is 1 at that rising edge, the port goes live.
- R5: Park-to-reset sets `tms_l` of each enabled port high from the next cycle onward.
- R6: Park-to-idle holds `tms_l` of each enabled port low from the next cycle onward.
- R7: Soft reset parks all three ports in Test-Logic-Reset whatever the mode register holds. `tms_l` becomes 3'b111 on the next cycle and stays high for at least five cycles unless a port is unparked.
- R8: Return-to-wait parks a live port, or a port waiting to leave Test-Logic-Reset, in Test-Logic-Reset. A port parked in Run-Test/Idle, or waiting to leave it, stays parked in Run-Test/Idle.
- R9: Live ports are chained in ascending index. `tdi_l[0]` = `scan_in`. `tdi_l[k+1]` is `tdo_l[k]` if port k is live, and otherwise `tdi_l[k]`. `scan_out` is the same function one stage past port 2. Ports that are parked or waiting are bypassed.
- R10: When several strobes arrive in one cycle, only one acts, in this order of precedence: soft reset, return-to-wait, park-to-reset, park-to-idle, unpark.
- R11: With mode 8'h07 and all three ports live, `scan_out` = `tdo_l[2]`, `tdi_l[2]` = `tdo_l[1]`, `tdi_l[1]` = `tdo_l[0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low reset |
| tms | input | 1 | Backplane test-mode-select |
| brg_state | input | 4 | Bridge TAP state code (4'hF reset, 4'hC idle) |
| mode_reg | input | 8 | Port enable mask, bits 2..0 used |
| cmd_unpark | input | 1 | Unpark strobe |
| cmd_park_tlr | input | 1 | Park-to-reset strobe |
| cmd_park_rti | input | 1 | Park-to-idle strobe |
| cmd_softreset | input | 1 | Soft reset strobe |
| cmd_gotowait | input | 1 | Return-to-wait strobe |
| scan_in | input | 1 | Serial data from the bridge |
| tdo_l | input | 3 | Serial data returned by each local chain |
| tms_l | output | 3 | Local test-mode-select per port |
| tdi_l | output | 3 | Serial data into each local chain |
| scan_out | output | 1 | Serial data back to the bridge |

## Verification
Directed sequences walk each port through unpark from both park states. They hold the bridge in the wrong state first, so a join that happens too early shows up as a `tms_l` mismatch. They then release the bridge into the matching state with the leaving TMS value, which separates a correct join from a stuck port. Collision cycles that carry several strobes tell the precedence order apart from any other order. A mode value with only the upper bits set shows whether those bits leak into the enables. A long random run mixes bridge states, TMS values, masks and strobe bursts, and compares each output against a bench model. This catches wrong chain ordering through the `tdo_l` patterns, and catches park states that do not survive return-to-wait.

// File: rtl/lsp_pkg.sv
package lsp_pkg;
  localparam int unsigned NUM_PORTS = 3;
  localparam int unsigned MODE_W    = 8;
  localparam int unsigned STATE_W   = 4;
  localparam logic [STATE_W-1:0] TAP_TLR = 4'hF;
  localparam logic [STATE_W-1:0] TAP_RTI = 4'hC;

  typedef enum logic [2:0] {
    PS_TLR  = 3'd0,   // parked, local TAP held in reset
    PS_RTI  = 3'd1,   // parked, local TAP held in idle
    PS_WTLR = 3'd2,   // unpark pending, waiting for bridge to leave reset
    PS_WRTI = 3'd3,   // unpark pending, waiting for bridge to leave idle
    PS_LIVE = 3'd4    // following backplane TMS
  } port_st_e;

  typedef struct packed {
    logic unpark;
    logic park_tlr;
    logic park_rti;
    logic softreset;
    logic gotowait;
  } lsp_cmd_t;
endpackage

// File: rtl/lsp_port_fsm.sv
module lsp_port_fsm
  import lsp_pkg::*;
(
  input  logic     tck,
  input  logic     trst_n,
  input  logic     en,
  input  logic     tms,
  input  logic     brg_tlr,
  input  logic     brg_rti,
  input  lsp_cmd_t cmd,
  output logic     tms_o,
  output logic     live_o
);
  port_st_e st, st_nx;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) st <= PS_TLR;
    else         st <= st_nx;
  end

  // Precedence: softreset > gotowait > park_tlr > park_rti > unpark
  always_comb begin
    st_nx = st;
    if (cmd.softreset) begin
      st_nx = PS_TLR;
    end else if (cmd.gotowait) begin
      st_nx = (st == PS_RTI || st == PS_WRTI) ? PS_RTI : PS_TLR;
    end else if (cmd.park_tlr && en) begin
      st_nx = PS_TLR;
    end else if (cmd.park_rti && en) begin
      st_nx = PS_RTI;
    end else if (cmd.unpark && en && st == PS_TLR) begin
      st_nx = PS_WTLR;
    end else if (cmd.unpark && en && st == PS_RTI) begin
      st_nx = PS_WRTI;
    end else begin
      unique case (st)
        PS_WTLR: if (brg_tlr && !tms) st_nx = PS_LIVE;
        PS_WRTI: if (brg_rti &&  tms) st_nx = PS_LIVE;
        default: st_nx = st;
      endcase
    end
  end

  always_comb begin
    unique case (st)
      PS_TLR:  tms_o = 1'b1;
      PS_RTI:  tms_o = 1'b0;
      PS_WTLR: tms_o = brg_tlr ? tms : 1'b1;
      PS_WRTI: tms_o = brg_rti ? tms : 1'b0;
      PS_LIVE: tms_o = tms;
      default: tms_o = 1'b1;
    endcase
  end

  assign live_o = (st == PS_LIVE);

  logic no_hi_cmd;
  assign no_hi_cmd = !cmd.softreset && !cmd.gotowait;

  a_r7_softreset_high: assert property (@(posedge tck) disable iff (!trst_n)
    cmd.softreset |=> tms_o);
  a_r5_parktlr_high: assert property (@(posedge tck) disable iff (!trst_n)
    (no_hi_cmd && cmd.park_tlr && en) |=> tms_o);
  a_r6_parkrti_low: assert property (@(posedge tck) disable iff (!trst_n)
    (no_hi_cmd && !cmd.park_tlr && cmd.park_rti && en) |=> !tms_o);
  a_r3_join_tlr: assert property (@(posedge tck) disable iff (!trst_n)
    (st == PS_WTLR && brg_tlr && !tms && no_hi_cmd && !cmd.park_tlr && !cmd.park_rti)
      |=> live_o);
  a_r2_disabled_stays: assert property (@(posedge tck) disable iff (!trst_n)
    (!en && no_hi_cmd && st == PS_TLR) |=> (st == PS_TLR));
  a_r8_rti_survives: assert property (@(posedge tck) disable iff (!trst_n)
    (cmd.gotowait && !cmd.softreset && st == PS_RTI) |=> !tms_o);
endmodule

// File: rtl/lsp_chain_mux.sv
module lsp_chain_mux #(
  parameter int unsigned N = 3
) (
  input  logic         scan_in,
  input  logic [N-1:0] live,
  input  logic [N-1:0] tdo_l,
  output logic [N-1:0] tdi_l,
  output logic         scan_out
);
  logic [N:0] feed;
  assign feed[0] = scan_in;

  for (genvar k = 0; k < N; k++) begin : g_stage
    assign tdi_l[k]  = feed[k];
    assign feed[k+1] = live[k] ? tdo_l[k] : feed[k];
  end

  assign scan_out = feed[N];

  always_comb begin
    if (live == '0) a_r9_bypass_all: assert (scan_out == scan_in);
  end
endmodule

// File: rtl/lsp_park_ctrl.sv
module lsp_park_ctrl
  import lsp_pkg::*;
(
  input  logic                 tck,
  input  logic                 trst_n,
  input  logic                 tms,
  input  logic [STATE_W-1:0]   brg_state,
  input  logic [MODE_W-1:0]    mode_reg,
  input  logic                 cmd_unpark,
  input  logic                 cmd_park_tlr,
  input  logic                 cmd_park_rti,
  input  logic                 cmd_softreset,
  input  logic                 cmd_gotowait,
  input  logic                 scan_in,
  input  logic [NUM_PORTS-1:0] tdo_l,
  output logic [NUM_PORTS-1:0] tms_l,
  output logic [NUM_PORTS-1:0] tdi_l,
  output logic                 scan_out
);
  logic brg_tlr, brg_rti;
  assign brg_tlr = (brg_state == TAP_TLR);
  assign brg_rti = (brg_state == TAP_RTI);

  lsp_cmd_t cmd;
  assign cmd.unpark    = cmd_unpark;
  assign cmd.park_tlr  = cmd_park_tlr;
  assign cmd.park_rti  = cmd_park_rti;
  assign cmd.softreset = cmd_softreset;
  assign cmd.gotowait  = cmd_gotowait;

  logic [NUM_PORTS-1:0] port_en;
  logic [NUM_PORTS-1:0] live;
  assign port_en = mode_reg[NUM_PORTS-1:0];

  for (genvar k = 0; k < NUM_PORTS; k++) begin : g_port
    lsp_port_fsm u_port (
      .tck    (tck),
      .trst_n (trst_n),
      .en     (port_en[k]),
      .tms    (tms),
      .brg_tlr(brg_tlr),
      .brg_rti(brg_rti),
      .cmd    (cmd),
      .tms_o  (tms_l[k]),
      .live_o (live[k])
    );
  end

  lsp_chain_mux #(.N(NUM_PORTS)) u_chain (
    .scan_in (scan_in),
    .live    (live),
    .tdo_l   (tdo_l),
    .tdi_l   (tdi_l),
    .scan_out(scan_out)
  );

  always_comb begin
    if (!trst_n) a_r1_reset_high: assert (tms_l == '1);
  end
endmodule

// File: tb/tb_lsp_park_ctrl.sv
module tb_lsp_park_ctrl;
  logic       tck = 1'b0;
  logic       trst_n = 1'b0;
  logic       tms = 1'b1;
  logic [3:0] brg_state = 4'hF;
  logic [7:0] mode_reg = 8'h00;
  logic       c_unp = 0, c_ptlr = 0, c_prti = 0, c_sr = 0, c_gw = 0;
  logic       scan_in = 0;
  logic [2:0] tdo_l = 3'b000;
  logic [2:0] tms_l, tdi_l;
  logic       scan_out;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int ms [3];   // 0 TLR, 1 RTI, 2 WTLR, 3 WRTI, 4 LIVE

  always #4 tck = ~tck;

  lsp_park_ctrl dut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .brg_state(brg_state),
    .mode_reg(mode_reg), .cmd_unpark(c_unp), .cmd_park_tlr(c_ptlr),
    .cmd_park_rti(c_prti), .cmd_softreset(c_sr), .cmd_gotowait(c_gw),
    .scan_in(scan_in), .tdo_l(tdo_l), .tms_l(tms_l), .tdi_l(tdi_l),
    .scan_out(scan_out)
  );

  function automatic logic exp_tms(int s);
    case (s)
      0: return 1'b1;
      1: return 1'b0;
      2: return (brg_state == 4'hF) ? tms : 1'b1;
      3: return (brg_state == 4'hC) ? tms : 1'b0;
      default: return tms;
    endcase
  endfunction

  function automatic int next_st(int s, logic en);
    if (c_sr) return 0;
    if (c_gw) return (s == 1 || s == 3) ? 1 : 0;
    if (c_ptlr && en) return 0;
    if (c_prti && en) return 1;
    if (c_unp && en && s == 0) return 2;
    if (c_unp && en && s == 1) return 3;
    if (s == 2 && brg_state == 4'hF && !tms) return 4;
    if (s == 3 && brg_state == 4'hC && tms) return 4;
    return s;
  endfunction

  task automatic check_now(string tag);
    logic [2:0] et, ed;
    logic feed;
    feed = scan_in;
    for (int k = 0; k < 3; k++) begin
      et[k] = exp_tms(ms[k]);
      ed[k] = feed;
      if (ms[k] == 4) feed = tdo_l[k];
    end
    n_chk++;
    if (tms_l !== et) begin
      n_bad++;
      $display("FAIL %s tms_l act=%b exp=%b", tag, tms_l, et);
    end
    n_chk++;
    if (tdi_l !== ed || scan_out !== feed) begin
      n_bad++;
      $display("FAIL %s chain act=%b/%b exp=%b/%b", tag, tdi_l, scan_out, ed, feed);
    end
  endtask

  task automatic step(logic [3:0] bs, logic t, logic [4:0] c, logic [7:0] md, string tag);
    @(negedge tck);
    brg_state = bs; tms = t; mode_reg = md;
    {c_gw, c_sr, c_prti, c_ptlr, c_unp} = c;
    scan_in = 1'($urandom); tdo_l = 3'($urandom);
    #1 check_now(tag);
    @(posedge tck);
    for (int k = 0; k < 3; k++) ms[k] = next_st(ms[k], md[k]);
  endtask

  localparam logic [4:0] C_NONE = 5'b00000, C_UNP = 5'b00001, C_PTLR = 5'b00010,
                         C_PRTI = 5'b00100, C_SR = 5'b01000, C_GW = 5'b10000;

  initial begin
    repeat (150000) @(posedge tck);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1149));
    for (int k = 0; k < 3; k++) ms[k] = 0;
    #3 scan_in = 1; tdo_l = 3'b010;
    #1 check_now("R1 in reset");
    #20 trst_n = 1;
    step(4'h3, 0, C_NONE, 8'h00, "R1");
    // R2: upper mode bits ignored
    step(4'h6, 1, C_UNP, 8'hF8, "R2");
    step(4'hF, 0, C_NONE, 8'hF8, "R2");
    step(4'hC, 1, C_NONE, 8'hF8, "R2");
    // R3 / R11: unpark all from reset park, hold bridge elsewhere first
    step(4'h6, 1, C_UNP, 8'h07, "R3");
    step(4'h2, 0, C_NONE, 8'h07, "R3");
    step(4'hC, 0, C_NONE, 8'h07, "R3");
    step(4'hF, 1, C_NONE, 8'h07, "R3");
    step(4'hF, 0, C_NONE, 8'h07, "R3");
    for (int i = 0; i < 4; i++) step(4'h1, 1'(i), C_NONE, 8'h07, "R11");
    // R6 + R8: park port 1 in idle, others to reset, then return-to-wait
    step(4'hD, 0, C_PRTI, 8'h02, "R6");
    step(4'h5, 1, C_PTLR, 8'h05, "R5");
    step(4'h5, 1, C_NONE, 8'h00, "R6");
    step(4'h5, 1, C_GW, 8'h07, "R8");
    step(4'h0, 1, C_NONE, 8'h07, "R8");
    // R4: unpark from idle park
    step(4'h4, 1, C_UNP, 8'h02, "R4");
    step(4'hF, 1, C_NONE, 8'h02, "R4");
    step(4'hC, 0, C_NONE, 8'h02, "R4");
    step(4'hC, 1, C_NONE, 8'h02, "R4");
    step(4'h7, 0, C_NONE, 8'h02, "R4");
    // R9: single live port in the middle
    for (int i = 0; i < 4; i++) step(4'h3, 1'(i), C_NONE, 8'h00, "R9");
    // R7: soft reset with empty mask, held five cycles
    step(4'h3, 0, C_SR, 8'h00, "R7");
    for (int i = 0; i < 5; i++) step(4'h9, 0, C_NONE, 8'h00, "R7");
    // R10: collisions
    step(4'h3, 0, C_PRTI | C_PTLR | C_UNP, 8'h07, "R10");
    step(4'h3, 0, C_PRTI | C_UNP, 8'h07, "R10");
    step(4'h3, 0, C_GW | C_PTLR, 8'h07, "R10");
    step(4'h3, 0, C_SR | C_GW | C_PRTI, 8'h07, "R10");
    step(4'h3, 0, C_NONE, 8'h07, "R10");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] bs;
      logic [4:0] c;
      logic [7:0] md;
      int sel;
      sel = int'($urandom_range(0, 2));
      bs = (sel == 0) ? 4'hF : (sel == 1) ? 4'hC : 4'($urandom);
      c = '0;
      for (int b = 0; b < 5; b++) if ($urandom_range(0, 11) == 0) c[b] = 1'b1;
      md = ($urandom_range(0, 1) == 0) ? 8'h07 : 8'($urandom);
      step(bs, 1'($urandom), c, md, "R10 random");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule